// File: doc/BRIEF.md
# Periodic Interrupt Timer with Optional Prescaler

This block produces a recurring interrupt request at a software-chosen rate. Software writes a 9-bit control word holding an 8-bit period and a prescale enable. The timer counts system clock ticks (or ticks divided by 512 when the prescale enable is set) and raises a sticky interrupt request once per period. The request stays pending until an acknowledge pulse clears it.

A period of zero stops the timer entirely. The prescale enable comes out of reset as the inverse of a mode pin level, sampled while reset is held, so board strapping picks the default time base. Any write restarts the count from the new period and clears the prescale divider, which gives software a clean phase reference.

Top module: `periodic_irq_timer`

## Requirements
- R1: While `rstN` is low, the prescale enable (`rdData[8]`) takes the inverse of `modePin` at each clock edge, the period (`rdData[7:0]`) becomes 0 and `irqPending` becomes 0. After reset is released, `modePin` has no effect.
- R2: After a clock edge with `wrEn` high, `rdData` equals the written word, with bit 8 as the prescale enable and bits 7:0 as the period.
- R3: With the prescale enable at 0 and a period N of 1 to 255, `irqPending` first becomes set N clock edges after the write edge, and each later expiry follows N edges after the previous one.
- R4: With the prescale enable at 1 and a period N, each expiry takes 512·N clock edges, counted from the write edge and then from the previous expiry.
- R5: While the period is 0, no expiry occurs and `irqPending` never becomes set. Writing 0 to a running timer stops it.
- R6: A write restarts the count from the newly written period and clears the prescale divider. The next expiry is timed from the write edge, not from the earlier phase.
- R7: Once set, `irqPending` stays 1 until a clock edge with `ackPulse` high, which clears it. Writes do not clear it.
- R8: When an expiry and `ackPulse` fall on the same clock edge, `irqPending` stays 1.
- R9: A period of 1 without prescaling causes an expiry on every clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| modePin | input | 1 | Mode strap; its inverse sets the prescale reset default |
| wrEn | input | 1 | Write strobe for the control word |
| wrData | input | 9 | Write data: bit 8 prescale enable, bits 7:0 period |
| rdData | output | 9 | Current control word, same layout as `wrData` |
| ackPulse | input | 1 | Acknowledge that clears the pending request |
| irqPending | output | 1 | Sticky interrupt request |

## Verification
Every result is counted in clock edges from the edge that registers the write. Readback is due one edge later. The first expiry is due N edges later, or 512·N edges when the prescaler is on. A clearing acknowledge acts on the edge that samples it. The bench drives inputs and samples outputs on falling edges, and it counts falling edges after the write edge. The first falling edge with `irqPending` high therefore gives the exact expiry edge number. Repeat intervals are timed from the acknowledge edge and have one added back, so they are compared against the same N or 512·N figure.

// File: rtl/pit_pkg.sv
package pit_pkg;
  // strobes issued by the control section to the counting datapath
  typedef struct packed {
    logic restart;  // reload the counter from the write data
    logic tick;     // one (possibly prescaled) timer tick
    logic run;      // period is nonzero
  } pitStrobes_t;
endpackage

// File: rtl/pit_ctrl.sv
module pit_ctrl
  import pit_pkg::*;
#(
  parameter int COUNT_W      = 8,
  parameter int PRESCALE_DIV = 512
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               modePin,
  input  logic               wrEn,
  input  logic [COUNT_W:0]   wrData,
  input  logic               ackPulse,
  input  logic               expire,
  output pitStrobes_t        strobes,
  output logic [COUNT_W-1:0] periodVal,
  output logic               prescaleOn,
  output logic               irqPending
);
  logic runS;
  logic divDone;

  // control word: prescale default follows inverted strap during reset
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prescaleOn <= ~modePin;
      periodVal  <= '0;
    end else if (wrEn) begin
      prescaleOn <= wrData[COUNT_W];
      periodVal  <= wrData[COUNT_W-1:0];
    end
  end

  assign runS = (periodVal != '0);

  generate
    if (PRESCALE_DIV > 1) begin : g_div
      localparam int DIV_W = $clog2(PRESCALE_DIV);
      localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(PRESCALE_DIV - 1);
      logic [DIV_W-1:0] divCnt;

      always_ff @(posedge clk) begin
        if (!rstN || wrEn || !runS || !prescaleOn) begin
          divCnt <= '0;
        end else if (divCnt == DIV_LAST) begin
          divCnt <= '0;
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end

      assign divDone = !prescaleOn || (divCnt == DIV_LAST);
    end else begin : g_nodiv
      assign divDone = 1'b1;
    end
  endgenerate

  assign strobes.restart = wrEn;
  assign strobes.run     = runS;
  assign strobes.tick    = runS && !wrEn && divDone;

  // sticky request; a fresh expiry wins over a simultaneous acknowledge
  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqPending <= 1'b0;
    end else begin
      irqPending <= expire || (irqPending && !ackPulse);
    end
  end
endmodule

// File: rtl/pit_datapath.sv
module pit_datapath
  import pit_pkg::*;
#(
  parameter int COUNT_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  pitStrobes_t        strobes,
  input  logic [COUNT_W-1:0] periodVal,
  input  logic [COUNT_W-1:0] loadVal,
  output logic               expire
);
  localparam logic [COUNT_W-1:0] ONE = COUNT_W'(1);

  logic [COUNT_W-1:0] downCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      downCnt <= '0;
    end else if (strobes.restart) begin
      downCnt <= loadVal;
    end else if (strobes.tick) begin
      if (downCnt <= ONE) begin
        downCnt <= periodVal;
      end else begin
        downCnt <= downCnt - ONE;
      end
    end
  end

  assign expire = strobes.tick && strobes.run && (downCnt == ONE);
endmodule

// File: rtl/periodic_irq_timer.sv
module periodic_irq_timer
  import pit_pkg::*;
#(
  parameter int COUNT_W      = 8,
  parameter int PRESCALE_DIV = 512
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modePin,
  input  logic             wrEn,
  input  logic [COUNT_W:0] wrData,
  output logic [COUNT_W:0] rdData,
  input  logic             ackPulse,
  output logic             irqPending
);
  pitStrobes_t        strobeS;
  logic [COUNT_W-1:0] periodS;
  logic               prescaleS;
  logic               expireS;
  logic               tickS;

  pit_ctrl #(.COUNT_W(COUNT_W), .PRESCALE_DIV(PRESCALE_DIV)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .modePin    (modePin),
    .wrEn       (wrEn),
    .wrData     (wrData),
    .ackPulse   (ackPulse),
    .expire     (expireS),
    .strobes    (strobeS),
    .periodVal  (periodS),
    .prescaleOn (prescaleS),
    .irqPending (irqPending)
  );

  pit_datapath #(.COUNT_W(COUNT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobeS),
    .periodVal (periodS),
    .loadVal   (wrData[COUNT_W-1:0]),
    .expire    (expireS)
  );

  assign tickS  = strobeS.tick;
  assign rdData = {prescaleS, periodS};
endmodule

// File: rtl/pit_checker.sv
module pit_checker #(
  parameter int COUNT_W      = 8,
  parameter int PRESCALE_DIV = 512
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [COUNT_W:0] wrData,
  input logic [COUNT_W:0] rdData,
  input logic             ackPulse,
  input logic             irqPending,
  input logic             expire,
  input logic             tick
);
  // R2
  readback_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (rdData == $past(wrData)));

  // R5
  off_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((rdData[COUNT_W-1:0] == '0) && !irqPending) |=> !irqPending);

  // R7
  pending_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqPending && !ackPulse) |=> irqPending);

  // R7
  pending_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqPending && ackPulse && !expire) |=> !irqPending);

  // R8
  ack_collide_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackPulse && expire) |=> irqPending);

  // R3
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqPending) |-> $past(expire));

  generate
    if (PRESCALE_DIV > 1) begin : g_divchk
      // R4
      sparse_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
        (rdData[COUNT_W] && tick && !wrEn) |=> !tick);
    end
  endgenerate
endmodule

bind periodic_irq_timer pit_checker #(
  .COUNT_W(COUNT_W), .PRESCALE_DIV(PRESCALE_DIV)
) u_pitChk (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .wrData     (wrData),
  .rdData     (rdData),
  .ackPulse   (ackPulse),
  .irqPending (irqPending),
  .expire     (expireS),
  .tick       (tickS)
);

// File: tb/tb_periodic_irq_timer.sv
module tb_periodic_irq_timer;
  localparam int CW  = 8;
  localparam int DIV = 512;
  // prescale, period, expected edges per expiry
  localparam int VEC [0:6][0:2] = '{
    '{0, 5, 5}, '{0, 1, 1}, '{0, 2, 2}, '{0, 37, 37},
    '{0, 255, 255}, '{1, 1, DIV}, '{1, 2, 2*DIV}};

  logic clk = 1'b0, rstN = 1'b0, modePin = 1'b0, wrEn = 1'b0, ackPulse = 1'b0;
  logic [CW:0] wrData = '0;
  wire  [CW:0] rdData;
  wire         irqPending;
  int checks = 0, failures = 0, cyc = 0;

  always #4 clk = ~clk;

  periodic_irq_timer #(.COUNT_W(CW), .PRESCALE_DIV(DIV)) dut (
    .clk(clk), .rstN(rstN), .modePin(modePin), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .ackPulse(ackPulse), .irqPending(irqPending));

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic doWrite(input logic p, input int n);
    @(negedge clk);
    wrEn = 1'b1; wrData = {p, CW'(n)};
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitIrq(input int limit, output int k);
    k = 0;
    while (k < limit) begin
      @(negedge clk);
      k++;
      if (irqPending) return;
    end
    k = -1;
  endtask

  task automatic pulseAck;
    ackPulse = 1'b1;
    @(negedge clk);
    ackPulse = 1'b0;
  endtask

  task automatic clearAll;
    doWrite(1'b0, 0);
    pulseAck();
  endtask

  initial begin
    int k;
    // R1: reset with strap low gives prescale on
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check("R1", "prescale after reset strap0", int'(rdData[CW]), 1);
    check("R1", "period after reset", int'(rdData[CW-1:0]), 0);
    check("R1", "pending after reset", int'(irqPending), 0);
    modePin = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "strap ignored after reset", int'(rdData[CW]), 1);

    // vector table: readback, first expiry and repeat interval
    for (int v = 0; v < 7; v++) begin
      clearAll();
      doWrite(VEC[v][0] != 0, VEC[v][1]);
      check("R2", "readback", int'(rdData), VEC[v][0] * 256 + VEC[v][1]);
      waitIrq(3000, k);
      check(VEC[v][0] != 0 ? "R4" : (VEC[v][1] == 1 ? "R9" : "R3"),
            "first expiry edge", k, VEC[v][2]);
      if (VEC[v][1] > 1) begin
        pulseAck();
        check("R7", "ack clears", int'(irqPending), 0);
        waitIrq(3000, k);
        check(VEC[v][0] != 0 ? "R4" : "R3", "repeat interval", k + 1, VEC[v][2]);
      end
    end

    // R5: zero period is silent, undivided and prescaled
    clearAll();
    doWrite(1'b0, 0);
    repeat (20) @(negedge clk);
    check("R5", "zero period undivided", int'(irqPending), 0);
    doWrite(1'b1, 0);
    repeat (1100) @(negedge clk);
    check("R5", "zero period prescaled", int'(irqPending), 0);
    doWrite(1'b0, 3);
    doWrite(1'b0, 0);
    repeat (10) @(negedge clk);
    check("R5", "write 0 stops timer", int'(irqPending), 0);

    // R6: restart, undivided and prescaled (divider cleared)
    doWrite(1'b0, 10);
    repeat (6) @(negedge clk);
    doWrite(1'b0, 10);
    waitIrq(3000, k);
    check("R6", "undivided restart edge", k, 10);
    clearAll();
    doWrite(1'b1, 1);
    repeat (300) @(negedge clk);
    doWrite(1'b1, 1);
    waitIrq(3000, k);
    check("R6", "prescaled restart edge", k, DIV);

    // R7: pending held without ack, not cleared by writes
    clearAll();
    doWrite(1'b0, 200);
    waitIrq(3000, k);
    check("R3", "period 200 edge", k, 200);
    doWrite(1'b0, 0);
    repeat (50) @(negedge clk);
    check("R7", "pending held", int'(irqPending), 1);
    pulseAck();
    check("R7", "pending cleared by ack", int'(irqPending), 0);

    // R8: ack coincides with expiry (period 1)
    doWrite(1'b0, 1);
    waitIrq(10, k);
    check("R9", "period 1 edge", k, 1);
    pulseAck();
    check("R8", "expiry beats ack", int'(irqPending), 1);
    clearAll();
    check("R8", "cleared after stop", int'(irqPending), 0);

    // R1: reset with strap high gives prescale off and clears pending
    doWrite(1'b1, 1);
    waitIrq(3000, k);
    modePin = 1'b1;
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    check("R1", "prescale after reset strap1", int'(rdData[CW]), 0);
    check("R1", "pending cleared by reset", int'(irqPending), 0);
    check("R1", "period cleared by reset", int'(rdData[CW-1:0]), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule